// File: doc/BRIEF.md
# I2C Serial Memory Random-Access Master

This block is a bus master for two-wire serial memories. It carries out one transfer per request: a single-byte random write or a single-byte random read. A request is a one-cycle start strobe together with a direction select, a 3-bit chip select, a 16-bit memory address, an address-width select and, for writes, a data byte. The block drives the clock line and pulls the data line low through an output enable. It samples the data line through a separate input. When the transfer ends it returns a one-cycle done pulse, an error flag and, for reads, the byte that was fetched.

A write sends the device byte in write mode, then one or two address bytes, then the data byte, and closes with a stop. A read sends the same device and address bytes, then issues a repeated start and the device byte in read mode. It then clocks in one byte, answers it with a not-acknowledge and closes with a stop. If any byte the master sends is refused, the master stops the bus at once and reports an error.

The bus clock comes from a divider on the system clock. Each bus clock period is split into four equal quarters. Data changes in the middle of the low half and is sampled in the middle of the high half.

Top module: `i2c_mem_master`

## Requirements
- R1: After a synchronous active-low reset, and at any time no transfer is running, `scl_o` is 1, `sda_oe_o` is 0, `done_o` is 0 and `err_o` is 0 (reset) with `rdata_o` = 0.
- R2: The data line changes only while `scl_o` is low. The exceptions are a start or repeated start (data falls while the clock is high) and a stop (data rises while the clock is high).
- R3: The device byte is 4'b1010, then `cs_i[2:0]`, then the direction bit (0 = write, 1 = read). Every byte goes out most significant bit first.
- R4: With `addr_two_i` = 1 the address phase is `addr_i[15:8]` followed by `addr_i[7:0]`. With `addr_two_i` = 0 it is `addr_i[7:0]` alone.
- R5: A write is exactly one start, the device byte in write mode, the address byte(s), the `wdata_i` byte and one stop.
- R6: A read is a start, the device byte in write mode, the address byte(s), a repeated start, the device byte in read mode and one received byte. The master keeps the data line released for all nine clocks of that byte, so the acknowledge bit reads 1 (not-acknowledge). A stop follows. `rdata_o` holds the received byte when `done_o` is high.
- R7: After each byte it sends, the master releases the data line and samples it on the ninth clock. A 1 there sets `err_o`, is followed directly by a stop, and ends the transfer with a done pulse.
- R8: `done_o` is high for exactly one system clock per transfer. `err_o` is valid with it and keeps its value until the next accepted start.
- R9: A start strobe that arrives while a transfer is running is ignored, and the running transfer uses the values latched when it was accepted. Input changes after acceptance have no effect.
- R10: The bus clock period is 4 × Q system clocks, where Q = CLK_HZ / (4 × SCL_HZ) rounded down, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| rd_i | input | 1 | 1 = random read, 0 = random write |
| cs_i | input | 3 | Chip-select bits of the device byte |
| addr_i | input | 16 | Memory address |
| addr_two_i | input | 1 | 1 = two address bytes, 0 = one |
| wdata_i | input | 8 | Byte to write |
| rdata_o | output | 8 | Byte read, valid with done |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| err_o | output | 1 | A sent byte was not acknowledged |
| scl_o | output | 1 | Bus clock level |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_i | input | 1 | Sampled data line level |

## Verification
The bench builds the master with CLK_HZ = 8,000,000 and SCL_HZ = 500,000. That gives a quarter divisor of 4 and a bus bit of 16 system clocks, so a complete two-byte-address read takes only a few hundred cycles. At this speed dozens of randomized transfers fit, covering both address widths, both directions and all chip-select values. The run also places a forced not-acknowledge at every byte position, including the device byte after the repeated start. The small divisor also keeps the exact bus clock spacing easy to check, and the bench compares it against its own computation of 4 × Q.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;

  localparam int unsigned MEM_ADDR_W = 16;
  localparam int unsigned CS_W       = 3;
  localparam int unsigned BYTE_W     = 8;
  localparam logic [3:0]  DEV_TYPE   = 4'b1010;
  localparam logic [3:0]  ACK_BIT    = 4'd8;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_DEVW, PH_ADRH, PH_ADRL,
    PH_WDAT, PH_RSTART, PH_DEVR, PH_RDAT, PH_STOP
  } phase_e;

  // Quarter-period length in system clocks, never below one.
  function automatic int unsigned quarter_div(int unsigned clk_hz, int unsigned scl_hz);
    int unsigned q;
    q = clk_hz / (4 * scl_hz);
    if (q == 0) q = 1;
    return q;
  endfunction

  function automatic logic [BYTE_W-1:0] dev_byte(logic [CS_W-1:0] cs, logic rd);
    return {DEV_TYPE, cs, rd};
  endfunction

  // Phase that follows an acknowledged byte.
  function automatic phase_e after_byte(phase_e ph, logic two, logic rd);
    phase_e n;
    case (ph)
      PH_DEVW: n = two ? PH_ADRH : PH_ADRL;
      PH_ADRH: n = PH_ADRL;
      PH_ADRL: n = rd ? PH_RSTART : PH_WDAT;
      PH_DEVR: n = PH_RDAT;
      default: n = PH_STOP;
    endcase
    return n;
  endfunction

  // Byte to shift out when entering a phase.
  function automatic logic [BYTE_W-1:0] byte_for(phase_e ph, logic [MEM_ADDR_W-1:0] a,
                                                  logic [BYTE_W-1:0] wd);
    logic [BYTE_W-1:0] b;
    case (ph)
      PH_ADRH: b = a[15:8];
      PH_ADRL: b = a[7:0];
      PH_WDAT: b = wd;
      default: b = '0;
    endcase
    return b;
  endfunction

  function automatic logic is_tx_byte(phase_e ph);
    return (ph == PH_DEVW) || (ph == PH_ADRH) || (ph == PH_ADRL) ||
           (ph == PH_WDAT) || (ph == PH_DEVR);
  endfunction

  // Clock and pull-down levels for one quarter of a slot: returns {scl, oe}.
  // Quarter 0 keeps the previous pull-down so data moves only at low-mid.
  function automatic logic [1:0] line_levels(phase_e ph, logic [1:0] q, logic [3:0] bitn,
                                             logic txbit, logic oe_now);
    logic scl, oe;
    scl = q[1];
    oe  = oe_now;
    case (ph)
      PH_IDLE:   begin scl = 1'b1; oe = 1'b0; end
      PH_START:  begin scl = 1'b1; oe = q[1]; end
      PH_RSTART: if (q != 2'd0) oe = (q == 2'd3);
      PH_STOP:   if (q != 2'd0) oe = (q != 2'd3);
      PH_RDAT:   if (q != 2'd0) oe = 1'b0;
      default:   if (q != 2'd0) oe = (bitn == ACK_BIT) ? 1'b0 : ~txbit;
    endcase
    return {scl, oe};
  endfunction

endpackage

// File: rtl/i2cm_quarter_timer.sv
`timescale 1ns/1ps
module i2cm_quarter_timer #(
  parameter int unsigned QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic       qtick,
  output logic [1:0] qidx
);
  localparam int unsigned CW = (QDIV > 1) ? $clog2(QDIV) : 1;

  logic [CW-1:0] cnt;

  assign qtick = run && (cnt == CW'(QDIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      qidx <= 2'd0;
    end else if (qtick) begin
      cnt  <= '0;
      qidx <= qidx + 2'd1;
    end else begin
      cnt  <= cnt + CW'(1);
    end
  end

  // R10: the quarter index moves only on a divider tick
  p_quarter_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(qtick) |-> (qidx == $past(qidx)));

endmodule

// File: rtl/i2cm_sequencer.sv
`timescale 1ns/1ps
module i2cm_sequencer
  import i2cm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  rd_i,
  input  logic [CS_W-1:0]       cs_i,
  input  logic [MEM_ADDR_W-1:0] addr_i,
  input  logic                  addr_two_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic                  qtick,
  input  logic [1:0]            qidx,
  input  logic                  sda_i,
  output phase_e                phase,
  output logic [3:0]            bitn,
  output logic                  txbit,
  output logic [BYTE_W-1:0]     rdata_o,
  output logic                  done_o,
  output logic                  err_o
);
  logic                  rd_q, two_q;
  logic [CS_W-1:0]       cs_q;
  logic [MEM_ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0]     wd_q;
  logic [BYTE_W-1:0]     tx_sh, rx_sh;
  logic                  ack_r;

  // Named events
  logic   accept, slot_end, sample_pt, ack_fail;
  phase_e nxt;

  assign accept    = start_i && (phase == PH_IDLE);
  assign slot_end  = qtick && (qidx == 2'd3);
  assign sample_pt = qtick && (qidx == 2'd2);
  assign ack_fail  = slot_end && (bitn == ACK_BIT) && is_tx_byte(phase) && ack_r;
  assign txbit     = tx_sh[BYTE_W-1];

  always_comb nxt = after_byte(phase, two_q, rd_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bitn    <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      ack_r   <= 1'b0;
      rdata_o <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      rd_q    <= 1'b0;
      two_q   <= 1'b0;
      cs_q    <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        rd_q   <= rd_i;
        two_q  <= addr_two_i;
        cs_q   <= cs_i;
        addr_q <= addr_i;
        wd_q   <= wdata_i;
        err_o  <= 1'b0;
        bitn   <= '0;
        phase  <= PH_START;
      end
      if (sample_pt) begin
        if (bitn == ACK_BIT)      ack_r <= sda_i;
        else if (phase == PH_RDAT) rx_sh <= {rx_sh[BYTE_W-2:0], sda_i};
      end
      if (slot_end) begin
        case (phase)
          PH_START: begin
            phase <= PH_DEVW;
            tx_sh <= dev_byte(cs_q, 1'b0);
            bitn  <= '0;
          end
          PH_RSTART: begin
            phase <= PH_DEVR;
            tx_sh <= dev_byte(cs_q, 1'b1);
            bitn  <= '0;
          end
          PH_STOP: begin
            phase  <= PH_IDLE;
            done_o <= 1'b1;
          end
          default: begin
            if (bitn != ACK_BIT) begin
              bitn  <= bitn + 4'd1;
              tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end else begin
              bitn <= '0;
              if (ack_fail) begin
                err_o <= 1'b1;
                phase <= PH_STOP;
              end else begin
                phase <= nxt;
                tx_sh <= byte_for(nxt, addr_q, wd_q);
                if (phase == PH_RDAT) rdata_o <= rx_sh;
              end
            end
          end
        endcase
      end
    end
  end

  // R7: a refused byte leads straight into the stop slot
  p_nack_to_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fail |=> (phase == PH_STOP));

  // R8: done lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: error flag holds while idle without a request
  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !start_i) |=> $stable(err_o));

  // R9: a request during a transfer leaves the latched request untouched
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && phase != PH_IDLE) |=> ($stable(addr_q) && $stable(rd_q) && $stable(cs_q)));

endmodule

// File: rtl/i2cm_line_driver.sv
`timescale 1ns/1ps
module i2cm_line_driver
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_e     phase,
  input  logic [1:0] qidx,
  input  logic [3:0] bitn,
  input  logic       txbit,
  output logic       scl_o,
  output logic       sda_oe_o
);
  logic [1:0] want;
  logic       cond_slot;

  assign cond_slot = (phase == PH_START) || (phase == PH_RSTART) || (phase == PH_STOP);

  always_comb want = line_levels(phase, qidx, bitn, txbit, sda_oe_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_o    <= 1'b1;
      sda_oe_o <= 1'b0;
    end else begin
      scl_o    <= want[1];
      sda_oe_o <= want[0];
    end
  end

  // R1: lines rest high and released while idle
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phase == PH_IDLE) |-> (scl_o && !sda_oe_o));

  // R2: data moves under a high clock only as a start or a stop
  p_sda_quiet_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && (sda_oe_o != $past(sda_oe_o))) |->
      ($past(cond_slot) && ($past(phase == PH_STOP) ? !sda_oe_o : sda_oe_o)));

  // R6: the master never pulls the line during the received byte
  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phase == PH_RDAT) |-> !sda_oe_o);

endmodule

// File: rtl/i2c_mem_master.sv
`timescale 1ns/1ps
module i2c_mem_master
  import i2cm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned SCL_HZ = 400_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [2:0]  cs_i,
  input  logic [15:0] addr_i,
  input  logic        addr_two_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        done_o,
  output logic        err_o,
  output logic        scl_o,
  output logic        sda_oe_o,
  input  logic        sda_i
);
  localparam int unsigned QDIV = quarter_div(CLK_HZ, SCL_HZ);

  phase_e     phase;
  logic       qtick;
  logic [1:0] qidx;
  logic [3:0] bitn;
  logic       txbit;
  logic       timer_run;

  assign timer_run = (phase != PH_IDLE);

  i2cm_quarter_timer #(.QDIV(QDIV)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (timer_run),
    .qtick (qtick),
    .qidx  (qidx)
  );

  i2cm_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_i       (rd_i),
    .cs_i       (cs_i),
    .addr_i     (addr_i),
    .addr_two_i (addr_two_i),
    .wdata_i    (wdata_i),
    .qtick      (qtick),
    .qidx       (qidx),
    .sda_i      (sda_i),
    .phase      (phase),
    .bitn       (bitn),
    .txbit      (txbit),
    .rdata_o    (rdata_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  i2cm_line_driver u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .qidx     (qidx),
    .bitn     (bitn),
    .txbit    (txbit),
    .scl_o    (scl_o),
    .sda_oe_o (sda_oe_o)
  );

endmodule

// File: tb/i2c_mem_master_tb.sv
`timescale 1ns/1ps
module i2c_mem_master_tb;
  localparam int unsigned CLK_HZ = 8_000_000;
  localparam int unsigned SCL_HZ = 500_000;
  localparam int EXP_PER = 4 * ((CLK_HZ / (4 * SCL_HZ)) < 1 ? 1 : (CLK_HZ / (4 * SCL_HZ)));

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, rd_i = 0, addr_two_i = 0;
  logic [2:0] cs_i = '0;
  logic [15:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic done_o, err_o, scl_o, sda_oe_o, sda_i;
  logic slv_oe = 1'b0;

  always #4 clk = ~clk;

  assign sda_i = ~(sda_oe_o | slv_oe);

  i2c_mem_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .cs_i(cs_i),
    .addr_i(addr_i), .addr_two_i(addr_two_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .done_o(done_o), .err_o(err_o),
    .scl_o(scl_o), .sda_oe_o(sda_oe_o), .sda_i(sda_i)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_val(logic [15:0] a);
    return a[15:8] ^ {a[6:0], a[7]} ^ 8'hC3;
  endfunction

  // ---------------- slave model ----------------
  logic [2:0]  slv_cs = 3'd0;
  bit          slv_two = 0;
  int          nack_at = -1;
  int          n_start = 0, n_stop = 0, n_dev = 0, n_adr = 0, wr_seen = 0;
  int          total_idx = 0, role_idx = 0, bitc = 0;
  bit          active = 0, rx = 1, in_ack = 0, go_tx = 0;
  logic        m_ack = 0, prev_scl = 1, prev_sda = 1;
  logic [7:0]  sh = 0, tx_byte = 0, dev0 = 0, dev1 = 0, wr_data = 0;
  logic [15:0] cur_addr = 0, wr_addr = 0;
  longint      cyc = 0, last_rise = -1, pmin = 1000000, pmax = 0;

  always @(negedge clk) begin
    logic sc, sd, ack;
    sc = scl_o;
    sd = sda_i;
    cyc++;
    if (sc && prev_scl && prev_sda && !sd) begin
      n_start++; active = 1; rx = 1; bitc = 0; in_ack = 0; role_idx = 0; go_tx = 0; slv_oe = 0;
    end else if (sc && prev_scl && !prev_sda && sd) begin
      n_stop++; active = 0; slv_oe = 0;
    end else if (active && sc && !prev_scl) begin
      if (last_rise >= 0) begin
        if (cyc - last_rise < pmin) pmin = cyc - last_rise;
        if (cyc - last_rise > pmax) pmax = cyc - last_rise;
      end
      last_rise = cyc;
      if (!in_ack) begin
        if (rx) sh = {sh[6:0], sd};
        bitc++;
      end else if (!rx) m_ack = sd;
    end else if (active && !sc && prev_scl) begin
      if (!in_ack && bitc == 8) begin
        in_ack = 1;
        if (rx) begin
          ack = (total_idx != nack_at);
          if (role_idx == 0) begin
            if (n_dev == 0) dev0 = sh; else dev1 = sh;
            n_dev++;
            if (sh[7:1] != {4'b1010, slv_cs}) ack = 0;
            else if (sh[0] && ack) begin go_tx = 1; tx_byte = mem_val(cur_addr); end
          end else if (role_idx <= (slv_two ? 2 : 1)) begin
            cur_addr = {cur_addr[7:0], sh}; n_adr++;
          end else if (ack) begin
            wr_seen++; wr_data = sh; wr_addr = cur_addr;
          end
          role_idx++; total_idx++;
          slv_oe = ack;
        end else slv_oe = 0;
      end else if (in_ack) begin
        in_ack = 0; bitc = 0; slv_oe = 0;
        if (go_tx) begin go_tx = 0; rx = 0; slv_oe = ~tx_byte[7]; end
      end else if (!rx && bitc < 8) slv_oe = ~tx_byte[7 - bitc];
    end
    prev_scl = sc;
    prev_sda = sda_i;
  end

  // ---------------- transaction task ----------------
  task automatic run_txn(input bit rd, input bit [2:0] cs, input bit [15:0] addr,
                         input bit two, input bit [7:0] wd, input bit [2:0] scs,
                         input int nk, input bit poke);
    int alen, waitc, k, exp_starts;
    bit exp_err;
    logic [15:0] ea;
    alen = two ? 2 : 1;
    ea = two ? addr : {8'h00, addr[7:0]};
    exp_err = (cs != scs) || (nk >= 0 && nk <= alen + 1);
    k = (cs != scs) ? 0 : nk;
    exp_starts = (rd && (!exp_err || k == alen + 1)) ? 2 : 1;
    slv_cs = scs; slv_two = two; nack_at = nk;
    n_start = 0; n_stop = 0; n_dev = 0; n_adr = 0; wr_seen = 0; total_idx = 0;
    cur_addr = 0; m_ack = 0; dev0 = 0; dev1 = 0; last_rise = -1; pmin = 1000000; pmax = 0;
    @(negedge clk);
    start_i = 1; rd_i = rd; cs_i = cs; addr_i = addr; addr_two_i = two; wdata_i = wd;
    @(negedge clk);
    // R9: scramble inputs once the request is latched
    start_i = 0; rd_i = ~rd; cs_i = ~cs; addr_i = ~addr; addr_two_i = ~two; wdata_i = ~wd;
    if (poke) begin
      repeat (40) @(negedge clk);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    waitc = 0;
    while (!done_o && waitc < 5000) begin @(negedge clk); waitc++; end
    check(done_o, "R8", "done seen", longint'(done_o), 1);
    check(err_o == exp_err, "R7", "error flag", longint'(err_o), longint'(exp_err));
    check(n_start == exp_starts, "R5/R6", "start count", n_start, exp_starts);
    check(n_stop == 1, "R5", "stop count", n_stop, 1);
    check(dev0 == {4'b1010, cs, 1'b0}, "R3", "write device byte", dev0, {4'b1010, cs, 1'b0});
    check(scl_o && !sda_oe_o, "R1", "idle lines after done", {scl_o, sda_oe_o}, 2'b10);
    if (pmax != 0)
      check(pmin == EXP_PER && pmax == EXP_PER, "R10", "clock period", pmax, EXP_PER);
    if (exp_starts == 2)
      check(dev1 == {4'b1010, cs, 1'b1}, "R6", "read device byte", dev1, {4'b1010, cs, 1'b1});
    if (!exp_err) begin
      check(n_adr == alen && cur_addr == ea, "R4", "address bytes", cur_addr, ea);
      if (rd) begin
        check(rdata_o == mem_val(ea), "R6", "read data", rdata_o, mem_val(ea));
        check(m_ack == 1'b1, "R6", "master not-acknowledge", m_ack, 1);
        check(wr_seen == 0, "R6", "no write on read", wr_seen, 0);
      end else begin
        check(wr_seen == 1 && wr_data == wd && wr_addr == ea, "R5", "written byte",
              {wr_addr, wr_data}, {ea, wd});
      end
    end else begin
      check(wr_seen == 0, "R7", "no write after refusal", wr_seen, 0);
    end
    @(negedge clk);
    check(!done_o, "R8", "done width", longint'(done_o), 0);
    repeat (5) @(negedge clk);
    check(err_o == exp_err, "R8", "error held", longint'(err_o), longint'(exp_err));
  endtask

  // ---------------- main ----------------
  initial begin
    int unsigned s;
    s = $urandom(32'h5EED_1234);
    repeat (5) @(negedge clk);
    check(scl_o && !sda_oe_o && !done_o && !err_o && rdata_o == 0, "R1", "reset state",
          {scl_o, sda_oe_o, done_o, err_o}, 4'b1000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // directed corner cases
    run_txn(0, 3'b100, 16'hA55A, 1, 8'h3C, 3'b100, -1, 0);
    run_txn(1, 3'b100, 16'hA55A, 1, 8'h00, 3'b100, -1, 0);
    run_txn(0, 3'b011, 16'h12F0, 0, 8'hFF, 3'b011, -1, 0);
    run_txn(1, 3'b011, 16'h12F0, 0, 8'h00, 3'b011, -1, 1);
    run_txn(1, 3'b000, 16'h0000, 1, 8'h00, 3'b000, -1, 0);
    run_txn(0, 3'b111, 16'hFFFF, 1, 8'h80, 3'b111, -1, 1);
    run_txn(0, 3'b001, 16'h4321, 1, 8'h55, 3'b010, -1, 0);  // R7 chip mismatch
    run_txn(1, 3'b101, 16'h0F0F, 1, 8'h00, 3'b101, 1, 0);   // R7 first address byte
    run_txn(1, 3'b101, 16'h0F0F, 1, 8'h00, 3'b101, 2, 0);   // R7 second address byte
    run_txn(1, 3'b101, 16'h0F0F, 1, 8'h00, 3'b101, 3, 0);   // R7 read device byte
    run_txn(0, 3'b110, 16'h00AB, 0, 8'h99, 3'b110, 2, 0);   // R7 data byte
    run_txn(0, 3'b110, 16'h00AB, 0, 8'h99, 3'b110, 1, 0);   // R7 single address byte
    // randomized
    for (int i = 0; i < 30; i++) begin
      bit rd, two, poke;
      logic [2:0] cs, scs;
      int nk;
      rd = 1'($urandom);
      two = 1'($urandom);
      poke = ($urandom % 3) == 0;
      cs = 3'($urandom);
      scs = (($urandom % 10) == 0) ? ~cs : cs;
      nk = (($urandom % 5) == 0) ? int'($urandom % 4) : -1;
      run_txn(rd, cs, 16'($urandom), two, 8'($urandom), scs, nk, poke);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule